// File: doc/BRIEF.md
# SPI Flash Fast-Read Word Fetcher

This block reads 32-bit words out of a serial NOR flash for a processor-side master. The master offers a 24-bit byte address on a valid/ready request channel. The block answers with a single-cycle response pulse that carries the word. The only flash command it ever issues is Fast Read (0x0B): an opcode byte, the address, one dummy byte, and then the data bits. The serial clock is made from the one system clock and runs at half its rate, in SPI mode 0.

After each word the flash is left selected and the serial clock is parked low. If the next request arrives in the very next cycle and asks for the following word (previous address + 4, wrapping at 24 bits), only 32 more clocks are issued, and that word arrives without a new command. In any other case the block deselects the flash for one serial-clock period before it goes on.

Back-pressure rules: a request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle or holding the flash selected after a word. The response channel cannot be stalled, so the master must take `rsp_data` in the cycle where `rsp_valid` is high.

Top module: `spi_word_fetch`

## Requirements
- R1: While reset (`rst_n` low, asynchronous) is applied and after it is released, `spi_cs_n` is 1, `spi_sck` is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A request is taken only on an edge with `req_valid` and `req_ready` both high. `req_ready` is low while a fetch or a deselect gap is in progress.
- R3: From idle, an accepted request to address A lowers `spi_cs_n` and shifts out, MSB first, the opcode 0x0B (8 bits) and A (24 bits). It then gives 8 dummy clocks and shifts in 32 data bits, MSB first. `rsp_data[31:24]` holds the byte at A, and bits 7:0 hold the byte at A+3.
- R4: `rsp_valid` is high for exactly one cycle per accepted request, and `rsp_data` is valid in that cycle. From idle, it rises on the 147th rising clock edge after the accepting edge.
- R5: `spi_sck` is high for exactly one system cycle per serial bit. `spi_mosi` changes only while `spi_sck` is low. `spi_miso` is captured on the system edge where `spi_sck` rises.
- R6: If, in the cycle right after a response, a request arrives for the previous address + 4, the block keeps `spi_cs_n` low, issues no opcode or address, and gives 32 data clocks. The response then arrives on the 65th edge after acceptance.
- R7: If no request is present in the cycle after a response, the block raises `spi_cs_n` on the next edge and holds it high for at least 2 cycles. The next request, even to the following address, then pays the full command.
- R8: A non-sequential request taken while the flash is held selected raises `spi_cs_n` for 2 cycles, then sends a full command. Its response arrives on the 149th edge after acceptance.
- R9: `spi_sck` is only high while `spi_cs_n` is low. It stays low while the block waits with the flash selected.
- R10: Sequential detection wraps at 24 bits: a request for 0x000000 right after a word at 0xFFFFFC streams without a new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the source of the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_addr | input | 24 | Flash byte address of the word |
| rsp_valid | output | 1 | One-cycle pulse: word delivered |
| rsp_data | output | 32 | Fetched word, first flash byte in the top bits |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Flash select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
Each result has a fixed due time, counted from the edge that accepts its request. A word fetched from idle is due 147 edges later, a streamed word 65 edges later, and a word after a forced deselect 149 edges later. The deselect itself is visible one edge after the idle cycle. The bench measures these counts exactly: it drives inputs and samples outputs on the falling clock edge, counts falling edges from acceptance until the pulse is seen, and compares the count with the figure given in the requirement. A bus-level flash model counts the commands it receives, so a streamed word can be told apart from one that was fetched again with a full command.

// File: rtl/spi_fetch_pkg.sv
package spi_fetch_pkg;
  localparam logic [7:0] FAST_READ_OP = 8'h0B;
  localparam int OP_W       = 8;
  localparam int DUMMY_BITS = 8;

  typedef enum logic [2:0] {
    ST_IDLE,   // deselected, ready
    ST_GAP,    // deselected, minimum high time
    ST_CMD,    // opcode + address
    ST_DUMMY,  // dummy clocks
    ST_DATA,   // data clocks
    ST_HOLD    // selected, parked, ready for a streamed word
  } fetch_state_e;
endpackage

// File: rtl/spi_bit_engine.sv
// Shifts a burst of nbits serial bits; two system cycles per bit.
module spi_bit_engine #(
  parameter int SH_W = 32,
  parameter int RX_W = 32,
  localparam int CNT_W = $clog2(SH_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] nbits,
  input  logic [SH_W-1:0]  tx_word,
  input  logic             miso,
  output logic             done,
  output logic             sck,
  output logic             mosi,
  output logic [RX_W-1:0]  rx_word
);
  logic             active, phase;
  logic [CNT_W-1:0] cnt;
  logic [SH_W-1:0]  sh_tx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      phase   <= 1'b0;
      sck     <= 1'b0;
      done    <= 1'b0;
      cnt     <= '0;
      sh_tx   <= '0;
      rx_word <= '0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (start) begin
          active <= 1'b1;
          phase  <= 1'b0;
          cnt    <= nbits;
          sh_tx  <= tx_word;
        end
      end else if (!phase) begin
        // rising serial edge: capture input bit
        sck     <= 1'b1;
        phase   <= 1'b1;
        rx_word <= {rx_word[RX_W-2:0], miso};
      end else begin
        // falling serial edge: advance output bit
        sck   <= 1'b0;
        phase <= 1'b0;
        sh_tx <= sh_tx << 1;
        cnt   <= cnt - CNT_W'(1);
        if (cnt == CNT_W'(1)) begin
          active <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end

  assign mosi = sh_tx[SH_W-1];
endmodule

// File: rtl/spi_seq_tracker.sv
// Remembers the address that would continue the current stream.
module spi_seq_tracker #(
  parameter int ADDR_W = 24,
  parameter int STRIDE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              is_next
);
  logic [ADDR_W-1:0] next_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    next_q <= '0;
    else if (load) next_q <= load_addr + ADDR_W'(STRIDE);
  end

  assign is_next = (req_addr == next_q);
endmodule

// File: rtl/spi_word_fetch.sv
module spi_word_fetch
  import spi_fetch_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int WORD_W  = 32,
  parameter int GAP_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_data,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int CMD_W = OP_W + ADDR_W;
  localparam int SH_W  = (CMD_W > WORD_W) ? CMD_W : WORD_W;
  localparam int CNT_W = $clog2(SH_W + 1);
  localparam int GAP_W = $clog2(GAP_CYC + 1);

  fetch_state_e      state;
  logic [ADDR_W-1:0] cur_addr;
  logic [GAP_W-1:0]  gap_cnt;
  logic              pend;
  logic              accept, is_next, eng_done, eng_start, trk_load;
  logic [CNT_W-1:0]  eng_nbits;
  logic [SH_W-1:0]   eng_tx;
  logic [WORD_W-1:0] eng_rx;

  assign req_ready = (state == ST_IDLE) || (state == ST_HOLD);
  assign accept    = req_valid && req_ready;
  assign trk_load  = (state == ST_DATA) && eng_done;

  function automatic logic [SH_W-1:0] cmd_frame(input logic [ADDR_W-1:0] a);
    return SH_W'({FAST_READ_OP, a}) << (SH_W - CMD_W);
  endfunction

  always_comb begin
    eng_start = 1'b0;
    eng_nbits = '0;
    eng_tx    = '0;
    unique case (state)
      ST_IDLE: if (accept) begin
        eng_start = 1'b1; eng_nbits = CNT_W'(CMD_W); eng_tx = cmd_frame(req_addr);
      end
      ST_GAP: if (gap_cnt == '0 && pend) begin
        eng_start = 1'b1; eng_nbits = CNT_W'(CMD_W); eng_tx = cmd_frame(cur_addr);
      end
      ST_CMD: if (eng_done) begin
        eng_start = 1'b1; eng_nbits = CNT_W'(DUMMY_BITS);
      end
      ST_DUMMY: if (eng_done) begin
        eng_start = 1'b1; eng_nbits = CNT_W'(WORD_W);
      end
      ST_HOLD: if (accept && is_next) begin
        eng_start = 1'b1; eng_nbits = CNT_W'(WORD_W);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      spi_cs_n  <= 1'b1;
      cur_addr  <= '0;
      gap_cnt   <= '0;
      pend      <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          cur_addr <= req_addr;
          spi_cs_n <= 1'b0;
          state    <= ST_CMD;
        end
        ST_GAP: begin
          if (gap_cnt == '0) begin
            if (pend) begin
              spi_cs_n <= 1'b0;
              pend     <= 1'b0;
              state    <= ST_CMD;
            end else begin
              state <= ST_IDLE;
            end
          end else begin
            gap_cnt <= gap_cnt - GAP_W'(1);
          end
        end
        ST_CMD:   if (eng_done) state <= ST_DUMMY;
        ST_DUMMY: if (eng_done) state <= ST_DATA;
        ST_DATA: if (eng_done) begin
          rsp_valid <= 1'b1;
          rsp_data  <= eng_rx;
          state     <= ST_HOLD;
        end
        ST_HOLD: begin
          if (accept && is_next) begin
            cur_addr <= req_addr;
            state    <= ST_DATA;
          end else begin
            // release, or jump: close the stream first
            spi_cs_n <= 1'b1;
            gap_cnt  <= GAP_W'(GAP_CYC - 1);
            pend     <= accept;
            if (accept) cur_addr <= req_addr;
            state    <= ST_GAP;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  spi_bit_engine #(.SH_W(SH_W), .RX_W(WORD_W)) u_engine (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (eng_start),
    .nbits   (eng_nbits),
    .tx_word (eng_tx),
    .miso    (spi_miso),
    .done    (eng_done),
    .sck     (spi_sck),
    .mosi    (spi_mosi),
    .rx_word (eng_rx)
  );

  spi_seq_tracker #(.ADDR_W(ADDR_W), .STRIDE(WORD_W / 8)) u_tracker (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (trk_load),
    .load_addr (cur_addr),
    .req_addr  (req_addr),
    .is_next   (is_next)
  );
endmodule

// File: rtl/spi_word_fetch_chk.sv
module spi_word_fetch_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic rsp_valid,
  input logic spi_sck,
  input logic spi_cs_n,
  input logic spi_mosi
);
  // R4
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R5
  sck_high_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sck) |=> $fell(spi_sck));

  // R5
  mosi_moves_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spi_mosi) |-> !spi_sck);

  // R9
  sck_only_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |-> !spi_cs_n);

  // R9
  parked_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !spi_cs_n) |-> !spi_sck);

  // R7
  deselect_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |=> spi_cs_n);

  // R2
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |-> !req_ready);
endmodule

bind spi_word_fetch spi_word_fetch_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .spi_sck   (spi_sck),
  .spi_cs_n  (spi_cs_n),
  .spi_mosi  (spi_mosi)
);

// File: tb/spi_word_fetch_bench.sv
module spi_word_fetch_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        spi_sck, spi_cs_n, spi_mosi;
  logic        spi_miso = 1'b0;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  spi_word_fetch u_spi_word_fetch (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  // ---- flash model ----
  function automatic logic [7:0] fbyte(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ {a[22:16], 1'b0} ^ 8'h3C;
  endfunction

  function automatic logic [31:0] exp_word(input logic [23:0] a);
    return {fbyte(a), fbyte(a + 24'd1), fbyte(a + 24'd2), fbyte(a + 24'd3)};
  endfunction

  int          bitcnt = 0;
  int          cmd_count = 0;
  int          desel_count = 0;
  logic [31:0] shreg = '0;
  logic [7:0]  last_op = '0;
  logic [23:0] last_addr = '0;

  always @(posedge spi_cs_n) begin
    bitcnt = 0;
    desel_count++;
  end

  always @(posedge spi_sck) begin
    if (!spi_cs_n) begin
      shreg = {shreg[30:0], spi_mosi};
      bitcnt++;
      if (bitcnt == 8) begin
        last_op = shreg[7:0];
        cmd_count++;
      end
      if (bitcnt == 32) last_addr = shreg[23:0];
    end
  end

  always @(negedge spi_sck) begin
    if (!spi_cs_n && bitcnt >= 40) begin
      logic [23:0] ba;
      int idx;
      idx = bitcnt - 40;
      ba  = last_addr + 24'(idx / 8);
      spi_miso = fbyte(ba)[7 - (idx % 8)];
    end
  end

  // ---- helpers ----
  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called on a falling edge; returns on the falling edge where rsp_valid is seen.
  task automatic fetch(input logic [23:0] a, output int lat, output logic [31:0] d);
    req_addr  = a;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!rsp_valid && lat < 400) begin
      @(negedge clk);
      lat++;
    end
    d = rsp_data;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(spi_cs_n == 1'b1, "R1 cs_n in reset", 32'(spi_cs_n), 32'd1);
    check(spi_sck == 1'b0 && rsp_valid == 1'b0, "R1 sck/rsp in reset",
          {30'd0, spi_sck, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1 && spi_cs_n == 1'b1, "R1 after release",
          {30'd0, req_ready, spi_cs_n}, 32'd3);
  endtask

  task automatic t_single(input logic [23:0] a);
    int lat; logic [31:0] d; int c0;
    c0 = cmd_count;
    fetch(a, lat, d);
    check(lat == 147, "R4 idle latency", 32'(lat), 32'd147);
    check(d == exp_word(a), "R3 data word", d, exp_word(a));
    check(last_op == 8'h0B, "R3 opcode", 32'(last_op), 32'h0B);
    check(last_addr == a, "R3 address", 32'(last_addr), 32'(a));
    check(cmd_count == c0 + 1, "R3 one command", 32'(cmd_count), 32'(c0 + 1));
    check(req_ready == 1'b1 && spi_cs_n == 1'b0, "R2 hold state",
          {30'd0, req_ready, spi_cs_n}, 32'd2);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R4 pulse length", 32'(rsp_valid), 32'd0);
    check(spi_cs_n == 1'b1 && req_ready == 1'b0, "R7 deselect, R2 busy",
          {30'd0, spi_cs_n, req_ready}, 32'd2);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_stream(input logic [23:0] a, input string tag);
    int lat; logic [31:0] d; int c0; int dz0;
    fetch(a, lat, d);
    check(d == exp_word(a), {tag, " first word"}, d, exp_word(a));
    c0 = cmd_count; dz0 = desel_count;
    for (int i = 1; i <= 3; i++) begin
      logic [23:0] na;
      na = a + 24'(4 * i);
      fetch(na, lat, d);
      check(lat == 65, {tag, " R6 stream latency"}, 32'(lat), 32'd65);
      check(d == exp_word(na), {tag, " R6 stream data"}, d, exp_word(na));
    end
    check(cmd_count == c0, {tag, " R6 no new command"}, 32'(cmd_count), 32'(c0));
    check(desel_count == dz0, {tag, " R6 cs held"}, 32'(desel_count), 32'(dz0));
    repeat (6) @(negedge clk);
  endtask

  task automatic t_release;
    int lat; logic [31:0] d; int c0;
    fetch(24'h000400, lat, d);
    @(negedge clk);
    @(negedge clk);
    check(spi_cs_n == 1'b1, "R7 cs high after idle cycle", 32'(spi_cs_n), 32'd1);
    c0 = cmd_count;
    fetch(24'h000404, lat, d);
    check(lat == 147, "R7 full command after release", 32'(lat), 32'd147);
    check(cmd_count == c0 + 1, "R7 command reissued", 32'(cmd_count), 32'(c0 + 1));
    check(d == exp_word(24'h000404), "R7 data", d, exp_word(24'h000404));
    repeat (6) @(negedge clk);
  endtask

  task automatic t_jump;
    int lat; logic [31:0] d; int c0; int dz0;
    fetch(24'h00A000, lat, d);
    c0 = cmd_count; dz0 = desel_count;
    fetch(24'h0B0010, lat, d);
    check(lat == 149, "R8 jump latency", 32'(lat), 32'd149);
    check(cmd_count == c0 + 1, "R8 new command", 32'(cmd_count), 32'(c0 + 1));
    check(desel_count == dz0 + 1, "R8 deselect between", 32'(desel_count), 32'(dz0 + 1));
    check(last_addr == 24'h0B0010, "R8 address", 32'(last_addr), 32'h0B0010);
    check(d == exp_word(24'h0B0010), "R8 data", d, exp_word(24'h0B0010));
    repeat (6) @(negedge clk);
  endtask

  task automatic t_wrap;
    int lat; logic [31:0] d; int c0;
    fetch(24'hFFFFFC, lat, d);
    check(d == exp_word(24'hFFFFFC), "R10 top word", d, exp_word(24'hFFFFFC));
    c0 = cmd_count;
    fetch(24'h000000, lat, d);
    check(lat == 65, "R10 wrap streams", 32'(lat), 32'd65);
    check(cmd_count == c0, "R10 no command", 32'(cmd_count), 32'(c0));
    check(d == exp_word(24'h000000), "R10 data", d, exp_word(24'h000000));
    repeat (6) @(negedge clk);
  endtask

  // R5 / R9 bus-level sampling on falling edges
  logic prev_mosi = 1'b0;
  int   bus_err = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (spi_sck && spi_mosi != prev_mosi) bus_err++;
      if (spi_sck && spi_cs_n) bus_err++;
    end
    prev_mosi = spi_mosi;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_single(24'h000000);
    t_single(24'h123454);
    t_stream(24'h000100, "R6a");
    t_release();
    t_jump();
    t_wrap();
    check(bus_err == 0, "R5 R9 bus rules", 32'(bus_err), 32'd0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule